// File: doc/BRIEF.md
# PCIe Completer Request Descriptor Decoder

This block sits on the receive side of a PCIe completer. Every incoming request comes in as a separate AXI4-Stream packet. The packet opens with a 16-byte descriptor, and payload beats may follow it. The block collects the descriptor, which takes two beats on a 64-bit data path and one beat on a 128-bit path. It decodes the descriptor into a set of registered request fields and adds flags derived from the request: a zero-length marker, a byte address and the byte offset inside the matched BAR. It also identifies messages and picks out their code, routing and destination ID.

For each non-posted request the block saves a completion context (requester ID, tag, traffic class and attributes) in a small first-word-fall-through queue. The completer logic reads this context later to build the completion. When the queue has no free slot, the block holds off the final descriptor beat of a non-posted request. Posted requests continue to flow. Payload beats go straight through on a separate valid.

The control is a three-state machine. `S_IDLE` waits for the first beat of a packet. `S_DESC_HI` exists only on the 64-bit path and waits for the upper descriptor half. `S_PAYLOAD` forwards beats until `tlast`. There are four transitions. `S_IDLE` to `S_DESC_HI` happens when the lower half is taken (64-bit only). `S_IDLE` or `S_DESC_HI` goes to `S_PAYLOAD` when the final descriptor beat is taken without `tlast`. The same two states go back to `S_IDLE` when that beat carries `tlast`. `S_PAYLOAD` goes to `S_IDLE` on the accepted last beat.

Top module: `cq_desc_decoder`

## Requirements
- R1: `dec_valid` is high for exactly the one cycle after the final descriptor beat is accepted. On a 128-bit path the final beat is the first beat of the packet. On a 64-bit path it is the second beat, and `dec_valid` stays low after the first beat.
- R2: The descriptor's 128 bits are decoded by fixed position: [1:0] address type, [74:64] Dword count, [78:75] request type, [95:80] requester ID, [103:96] tag, [114:112] BAR ID, [120:115] aperture, [123:121] traffic class, [126:124] attributes. On a 64-bit path, the first beat holds bits [63:0].
- R3: With `ARI_EN`=0, `dec_func` is bits [106:104] with its upper five bits forced to zero. With `ARI_EN`=1, it is all of bits [111:104].
- R4: `dec_byte_addr` is the Dword address (bits [63:2]) followed by two low bits. Those bits give the index (0 to 3) of the lowest set bit of the first byte enables, which are sampled on the first beat. All-zero enables give 0.
- R5: `dec_offset` equals `dec_byte_addr` with every bit at or above the aperture value N cleared. For example, N=12 keeps bits [11:0] and N=0 gives 0.
- R6: `dec_zero_len` is set when the request type is 0000 (memory read) or 0001 (memory write), the Dword count is 1, and all four first byte enables are 0.
- R7: Request types 0000, 0010 (I/O read), 0011 (I/O write) and 0100 to 0110 (atomics) are non-posted. Only these types raise `dec_non_posted` and push {requester ID, tag, TC, attributes} into the context queue. The queue gives entries back in arrival order, and `ctx_pop` removes the head.
- R8: While the context queue is full, `s_tready` is low on a final descriptor beat whose request type is non-posted. A posted request is still accepted. The held beat is accepted once an entry has been popped.
- R9: Types 1100 to 1110 are messages. They raise `dec_is_msg` and output the code (bits [111:104]) and routing (bits [114:112]). `dec_dest_vld` is set exactly when the request is a message whose routing is 010, and `dec_dest_id` is bits [15:0].
- R10: Beats after the descriptor show up on `pl_valid` with `pl_data` and `pl_last` equal to the incoming beat. Descriptor beats never raise `pl_valid`.
- R11: After reset, `dec_valid`, `ctx_valid` and `pl_valid` are 0 and `s_tready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | DATA_W | Request stream data |
| s_tvalid | input | 1 | Request stream valid |
| s_tlast | input | 1 | Last beat of the packet |
| s_first_be | input | 4 | First Dword byte enables, valid on the first beat |
| s_tready | output | 1 | Stream ready |
| dec_valid | output | 1 | Decoded fields valid pulse |
| dec_addr_type | output | 2 | Address type |
| dec_byte_addr | output | 64 | Byte address |
| dec_offset | output | 64 | Offset within the BAR aperture |
| dec_dw_cnt | output | 11 | Dword count |
| dec_req_type | output | 4 | Request type |
| dec_req_id | output | 16 | Requester ID |
| dec_tag | output | 8 | Tag |
| dec_func | output | 8 | Target function |
| dec_bar_id | output | 3 | Matched BAR |
| dec_aperture | output | 6 | BAR aperture (log2 bytes) |
| dec_tc | output | 3 | Traffic class |
| dec_attr | output | 3 | Attributes |
| dec_zero_len | output | 1 | Zero-length request |
| dec_non_posted | output | 1 | Request is non-posted |
| dec_is_msg | output | 1 | Request is a message |
| dec_msg_code | output | 8 | Message code |
| dec_msg_route | output | 3 | Message routing |
| dec_dest_id | output | 16 | Destination ID |
| dec_dest_vld | output | 1 | Destination ID is meaningful |
| pl_valid | output | 1 | Payload beat valid |
| pl_data | output | DATA_W | Payload beat data |
| pl_last | output | 1 | Payload last beat |
| ctx_pop | input | 1 | Remove head completion context |
| ctx_valid | output | 1 | Context queue not empty |
| ctx_req_id | output | 16 | Head context requester ID |
| ctx_tag | output | 8 | Head context tag |
| ctx_tc | output | 3 | Head context traffic class |
| ctx_attr | output | 3 | Head context attributes |

## Verification
The hardest case to reach is the back-pressure window. The queue must be full, a posted request must slip past, and then a non-posted descriptor must sit on the bus while `s_tready` is low. The stimulus reaches this state by sending four non-posted reads without popping, then a write, then one more read that it holds valid. It releases one entry partway through and checks that the held read is accepted only afterwards, and that the drained contexts come out in arrival order. Around this, a sweep covers all sixteen request types against all sixteen byte-enable patterns, with addresses, apertures and routing fields derived arithmetically. A second build on the 64-bit path with ARI enabled covers two-beat assembly.

// File: rtl/cq_dec_pkg.sv
package cq_dec_pkg;

    localparam int DESC_W = 128;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_DESC_HI = 2'd1,
        S_PAYLOAD = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic [15:0] req_id;
        logic [7:0]  tag;
        logic [2:0]  tc;
        logic [2:0]  attr;
    } cpl_ctx_t;

    typedef struct packed {
        logic [1:0]  addr_type;
        logic [63:0] byte_addr;
        logic [63:0] offset;
        logic [10:0] dw_cnt;
        logic [3:0]  req_type;
        logic [15:0] req_id;
        logic [7:0]  tag;
        logic [7:0]  func;
        logic [2:0]  bar_id;
        logic [5:0]  aperture;
        logic [2:0]  tc;
        logic [2:0]  attr;
        logic        zero_len;
        logic        non_posted;
        logic        is_msg;
        logic [7:0]  msg_code;
        logic [2:0]  msg_route;
        logic [15:0] dest_id;
        logic        dest_vld;
    } req_fields_t;

    function automatic logic type_non_posted(input logic [3:0] t);
        return (t == 4'b0000) || (t == 4'b0010) || (t == 4'b0011) ||
               (t == 4'b0100) || (t == 4'b0101) || (t == 4'b0110);
    endfunction

    function automatic logic type_message(input logic [3:0] t);
        return (t == 4'b1100) || (t == 4'b1101) || (t == 4'b1110);
    endfunction

endpackage

// File: rtl/cq_desc_assemble.sv
module cq_desc_assemble
    import cq_dec_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic [3:0]        s_first_be,
    output logic [DESC_W-1:0] desc,
    output logic [3:0]        be_eff
);

    generate
        if (DATA_W == 64) begin : g_two_beat
            logic [63:0] lo_q;
            logic [3:0]  be_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lo_q <= '0;
                    be_q <= '0;
                end else if (cap) begin
                    lo_q <= s_tdata;
                    be_q <= s_first_be;
                end
            end
            assign desc   = {s_tdata, lo_q};
            assign be_eff = be_q;
        end else begin : g_one_beat
            logic unused_ok;
            assign unused_ok = ^{cap, clk, rst_n};
            assign desc   = s_tdata[DESC_W-1:0];
            assign be_eff = s_first_be;
        end
    endgenerate

endmodule

// File: rtl/cq_field_unpack.sv
module cq_field_unpack
    import cq_dec_pkg::*;
#(
    parameter bit ARI_EN = 1'b0
) (
    input  logic [DESC_W-1:0] desc,
    input  logic [3:0]        be,
    output req_fields_t       f
);

    logic [1:0]  low_be;
    logic [63:0] baddr;
    logic [63:0] aper_mask;
    logic [7:0]  func_w;
    logic        unused_rsv;

    assign unused_rsv = ^{desc[127], desc[79]};

    generate
        if (ARI_EN) begin : g_ari
            assign func_w = desc[111:104];
        end else begin : g_legacy
            assign func_w = {5'd0, desc[106:104]};
        end
    endgenerate

    always_comb begin
        if (be[0])      low_be = 2'd0;
        else if (be[1]) low_be = 2'd1;
        else if (be[2]) low_be = 2'd2;
        else if (be[3]) low_be = 2'd3;
        else            low_be = 2'd0;
        baddr     = {desc[63:2], low_be};
        aper_mask = (64'd1 << desc[120:115]) - 64'd1;

        f.addr_type  = desc[1:0];
        f.byte_addr  = baddr;
        f.offset     = baddr & aper_mask;
        f.dw_cnt     = desc[74:64];
        f.req_type   = desc[78:75];
        f.req_id     = desc[95:80];
        f.tag        = desc[103:96];
        f.func       = func_w;
        f.bar_id     = desc[114:112];
        f.aperture   = desc[120:115];
        f.tc         = desc[123:121];
        f.attr       = desc[126:124];
        f.zero_len   = (desc[78:76] == 3'b000) && (desc[74:64] == 11'd1) && (be == 4'd0);
        f.non_posted = type_non_posted(desc[78:75]);
        f.is_msg     = type_message(desc[78:75]);
        f.msg_code   = desc[111:104];
        f.msg_route  = desc[114:112];
        f.dest_id    = desc[15:0];
        f.dest_vld   = f.is_msg && (desc[114:112] == 3'b010);
    end

endmodule

// File: rtl/cq_ctx_fifo.sv
module cq_ctx_fifo
    import cq_dec_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  cpl_ctx_t push_data,
    input  logic     pop,
    output cpl_ctx_t head,
    output logic     valid,
    output logic     full
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    cpl_ctx_t      mem_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [AW:0]   cnt_q;
    logic          pop_eff;

    assign pop_eff = pop && (cnt_q != '0);
    assign valid   = (cnt_q != '0);
    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign head    = mem_q[rd_q];

    always_ff @(posedge clk) begin
        if (push) mem_q[wr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push)    wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            if (pop_eff) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            unique case ({push, pop_eff})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop_eff) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/cq_desc_decoder.sv
module cq_desc_decoder
    import cq_dec_pkg::*;
#(
    parameter int DATA_W    = 128,
    parameter int CTX_DEPTH = 4,
    parameter bit ARI_EN    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    input  logic [3:0]        s_first_be,
    output logic              s_tready,
    output logic              dec_valid,
    output logic [1:0]        dec_addr_type,
    output logic [63:0]       dec_byte_addr,
    output logic [63:0]       dec_offset,
    output logic [10:0]       dec_dw_cnt,
    output logic [3:0]        dec_req_type,
    output logic [15:0]       dec_req_id,
    output logic [7:0]        dec_tag,
    output logic [7:0]        dec_func,
    output logic [2:0]        dec_bar_id,
    output logic [5:0]        dec_aperture,
    output logic [2:0]        dec_tc,
    output logic [2:0]        dec_attr,
    output logic              dec_zero_len,
    output logic              dec_non_posted,
    output logic              dec_is_msg,
    output logic [7:0]        dec_msg_code,
    output logic [2:0]        dec_msg_route,
    output logic [15:0]       dec_dest_id,
    output logic              dec_dest_vld,
    output logic              pl_valid,
    output logic [DATA_W-1:0] pl_data,
    output logic              pl_last,
    input  logic              ctx_pop,
    output logic              ctx_valid,
    output logic [15:0]       ctx_req_id,
    output logic [7:0]        ctx_tag,
    output logic [2:0]        ctx_tc,
    output logic [2:0]        ctx_attr
);

    localparam bit TWO_BEAT = (DATA_W < DESC_W);

    rx_state_e   state_q, state_d;
    logic        acc, final_beat, cap, desc_done, push, ctx_full;
    logic [DESC_W-1:0] desc;
    logic [3:0]  be_eff;
    req_fields_t fields, fields_q;
    logic        valid_q;
    cpl_ctx_t    ctx_in, ctx_head;

    cq_desc_assemble #(.DATA_W(DATA_W)) u_asm (
        .clk(clk), .rst_n(rst_n), .cap(cap), .s_tdata(s_tdata),
        .s_first_be(s_first_be), .desc(desc), .be_eff(be_eff)
    );

    cq_field_unpack #(.ARI_EN(ARI_EN)) u_unpack (
        .desc(desc), .be(be_eff), .f(fields)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (acc) begin
                if (TWO_BEAT)     state_d = S_DESC_HI;
                else if (s_tlast) state_d = S_IDLE;
                else              state_d = S_PAYLOAD;
            end
            S_DESC_HI: if (acc) state_d = s_tlast ? S_IDLE : S_PAYLOAD;
            S_PAYLOAD: if (acc && s_tlast) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        final_beat = 1'b0;
        s_tready   = 1'b1;
        pl_valid   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                final_beat = !TWO_BEAT;
                if (!TWO_BEAT) s_tready = !(fields.non_posted && ctx_full);
            end
            S_DESC_HI: begin
                final_beat = 1'b1;
                s_tready   = !(fields.non_posted && ctx_full);
            end
            S_PAYLOAD: pl_valid = s_tvalid;
            default: ;
        endcase
    end

    assign acc       = s_tvalid && s_tready;
    assign cap       = acc && (state_q == S_IDLE);
    assign desc_done = acc && final_beat;
    assign push      = desc_done && fields.non_posted;
    assign pl_data   = s_tdata;
    assign pl_last   = s_tlast;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            fields_q <= '0;
        end else begin
            valid_q <= desc_done;
            if (desc_done) fields_q <= fields;
        end
    end

    assign ctx_in = '{req_id: fields.req_id, tag: fields.tag, tc: fields.tc, attr: fields.attr};

    cq_ctx_fifo #(.DEPTH(CTX_DEPTH)) u_ctx (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(ctx_in),
        .pop(ctx_pop), .head(ctx_head), .valid(ctx_valid), .full(ctx_full)
    );

    assign ctx_req_id = ctx_head.req_id;
    assign ctx_tag    = ctx_head.tag;
    assign ctx_tc     = ctx_head.tc;
    assign ctx_attr   = ctx_head.attr;

    assign dec_valid      = valid_q;
    assign dec_addr_type  = fields_q.addr_type;
    assign dec_byte_addr  = fields_q.byte_addr;
    assign dec_offset     = fields_q.offset;
    assign dec_dw_cnt     = fields_q.dw_cnt;
    assign dec_req_type   = fields_q.req_type;
    assign dec_req_id     = fields_q.req_id;
    assign dec_tag        = fields_q.tag;
    assign dec_func       = fields_q.func;
    assign dec_bar_id     = fields_q.bar_id;
    assign dec_aperture   = fields_q.aperture;
    assign dec_tc         = fields_q.tc;
    assign dec_attr       = fields_q.attr;
    assign dec_zero_len   = fields_q.zero_len;
    assign dec_non_posted = fields_q.non_posted;
    assign dec_is_msg     = fields_q.is_msg;
    assign dec_msg_code   = fields_q.msg_code;
    assign dec_msg_route  = fields_q.msg_route;
    assign dec_dest_id    = fields_q.dest_id;
    assign dec_dest_vld   = fields_q.dest_vld;

    p_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (TWO_BEAT && dec_valid) |=> !dec_valid);

    p_func_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !ARI_EN) |-> (dec_func[7:3] == 5'd0));

    p_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> ((dec_offset & ~dec_byte_addr) == 64'd0));

    p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_zero_len) |-> (dec_dw_cnt == 11'd1 && dec_req_type[3:1] == 3'b000));

    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && !s_tready) |-> !ctx_pop || ctx_valid);

    p_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_dest_vld |-> (dec_is_msg && dec_msg_route == 3'b010));

endmodule

// File: tb/sim_cq_desc_decoder.sv
module sim_cq_desc_decoder;

    typedef struct packed {
        logic [1:0]  addr_type;
        logic [63:0] byte_addr;
        logic [63:0] offset;
        logic [10:0] dw_cnt;
        logic [3:0]  req_type;
        logic [15:0] req_id;
        logic [7:0]  tag;
        logic [7:0]  func;
        logic [2:0]  bar_id;
        logic [5:0]  aperture;
        logic [2:0]  tc;
        logic [2:0]  attr;
        logic        zero_len;
        logic        non_posted;
        logic        is_msg;
        logic [7:0]  msg_code;
        logic [2:0]  msg_route;
        logic [15:0] dest_id;
        logic        dest_vld;
    } obs_t;

    logic clk = 1'b0;
    always #10 clk = ~clk;
    logic rst_n = 1'b0;
    int n_chk = 0, n_fail = 0;

    // 128-bit, legacy function numbering
    logic [127:0] a_tdata = '0;
    logic a_tvalid = 0, a_tlast = 0, a_pop = 0;
    logic [3:0] a_be = '0;
    logic a_tready, a_dv, a_pl_valid, a_pl_last, a_ctx_valid;
    logic [127:0] a_pl_data;
    logic [15:0] a_crid; logic [7:0] a_ctag; logic [2:0] a_ctc, a_cattr;
    obs_t a_obs;

    cq_desc_decoder #(.DATA_W(128), .CTX_DEPTH(4), .ARI_EN(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .s_tdata(a_tdata), .s_tvalid(a_tvalid),
        .s_tlast(a_tlast), .s_first_be(a_be), .s_tready(a_tready), .dec_valid(a_dv),
        .dec_addr_type(a_obs.addr_type), .dec_byte_addr(a_obs.byte_addr),
        .dec_offset(a_obs.offset), .dec_dw_cnt(a_obs.dw_cnt), .dec_req_type(a_obs.req_type),
        .dec_req_id(a_obs.req_id), .dec_tag(a_obs.tag), .dec_func(a_obs.func),
        .dec_bar_id(a_obs.bar_id), .dec_aperture(a_obs.aperture), .dec_tc(a_obs.tc),
        .dec_attr(a_obs.attr), .dec_zero_len(a_obs.zero_len), .dec_non_posted(a_obs.non_posted),
        .dec_is_msg(a_obs.is_msg), .dec_msg_code(a_obs.msg_code), .dec_msg_route(a_obs.msg_route),
        .dec_dest_id(a_obs.dest_id), .dec_dest_vld(a_obs.dest_vld),
        .pl_valid(a_pl_valid), .pl_data(a_pl_data), .pl_last(a_pl_last),
        .ctx_pop(a_pop), .ctx_valid(a_ctx_valid), .ctx_req_id(a_crid), .ctx_tag(a_ctag),
        .ctx_tc(a_ctc), .ctx_attr(a_cattr)
    );

    // 64-bit, ARI numbering
    logic [63:0] b_tdata = '0;
    logic b_tvalid = 0, b_tlast = 0, b_pop = 0;
    logic [3:0] b_be = '0;
    logic b_tready, b_dv, b_pl_valid, b_pl_last, b_ctx_valid;
    logic [63:0] b_pl_data;
    logic [15:0] b_crid; logic [7:0] b_ctag; logic [2:0] b_ctc, b_cattr;
    obs_t b_obs;

    cq_desc_decoder #(.DATA_W(64), .CTX_DEPTH(4), .ARI_EN(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .s_tdata(b_tdata), .s_tvalid(b_tvalid),
        .s_tlast(b_tlast), .s_first_be(b_be), .s_tready(b_tready), .dec_valid(b_dv),
        .dec_addr_type(b_obs.addr_type), .dec_byte_addr(b_obs.byte_addr),
        .dec_offset(b_obs.offset), .dec_dw_cnt(b_obs.dw_cnt), .dec_req_type(b_obs.req_type),
        .dec_req_id(b_obs.req_id), .dec_tag(b_obs.tag), .dec_func(b_obs.func),
        .dec_bar_id(b_obs.bar_id), .dec_aperture(b_obs.aperture), .dec_tc(b_obs.tc),
        .dec_attr(b_obs.attr), .dec_zero_len(b_obs.zero_len), .dec_non_posted(b_obs.non_posted),
        .dec_is_msg(b_obs.is_msg), .dec_msg_code(b_obs.msg_code), .dec_msg_route(b_obs.msg_route),
        .dec_dest_id(b_obs.dest_id), .dec_dest_vld(b_obs.dest_vld),
        .pl_valid(b_pl_valid), .pl_data(b_pl_data), .pl_last(b_pl_last),
        .ctx_pop(b_pop), .ctx_valid(b_ctx_valid), .ctx_req_id(b_crid), .ctx_tag(b_ctag),
        .ctx_tc(b_ctc), .ctx_attr(b_cattr)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_desc(input int t, input int be);
        logic [127:0] d = '0;
        logic [63:0] a = 64'h0123_4567_89AB_CDEF * 64'(t + 1) + 64'(be * 977);
        d[63:2]    = a[61:0];
        d[1:0]     = 2'(be % 4);
        d[74:64]   = ((t + be) % 3 == 0) ? 11'd1 : 11'((t * 16 + be) % 257);
        d[78:75]   = 4'(t);
        d[95:80]   = 16'(16'hA000 + t * 16 + be);
        d[103:96]  = 8'(t * 16 + be);
        d[111:104] = 8'(t * 16 + be) ^ 8'h5A;
        d[114:112] = 3'((t + be) % 8);
        d[120:115] = 6'((t * 4 + be) % 64);
        d[123:121] = 3'(be % 8);
        d[126:124] = 3'(t % 8);
        return d;
    endfunction

    function automatic obs_t expect_of(input logic [127:0] d, input logic [3:0] be, input bit ari);
        obs_t o;
        int t = int'(d[78:75]);
        int ap = int'(d[120:115]);
        logic [1:0] lb = 2'd0;
        logic [63:0] mask;
        for (int i = 3; i >= 0; i--) if (be[i]) lb = 2'(i);
        mask = (ap == 0) ? 64'd0 : ({64{1'b1}} >> (64 - ap));
        o.addr_type  = d[1:0];
        o.byte_addr  = {d[63:2], lb};
        o.offset     = o.byte_addr & mask;
        o.dw_cnt     = d[74:64];
        o.req_type   = d[78:75];
        o.req_id     = d[95:80];
        o.tag        = d[103:96];
        o.func       = ari ? d[111:104] : (d[111:104] % 8);
        o.bar_id     = d[114:112];
        o.aperture   = d[120:115];
        o.tc         = d[123:121];
        o.attr       = d[126:124];
        o.zero_len   = (t <= 1) && (d[74:64] == 11'd1) && (be == 4'd0);
        o.non_posted = (t == 0) || (t >= 2 && t <= 6);
        o.is_msg     = (t >= 12 && t <= 14);
        o.msg_code   = d[111:104];
        o.msg_route  = d[114:112];
        o.dest_id    = d[15:0];
        o.dest_vld   = o.is_msg && (d[114:112] == 3'b010);
        return o;
    endfunction

    task automatic chk_fields(input obs_t a, input obs_t e);
        chk("R2 raw fields", {a.addr_type, a.dw_cnt, a.req_type, a.req_id, a.tag, a.bar_id, a.aperture, a.tc, a.attr},
                             {e.addr_type, e.dw_cnt, e.req_type, e.req_id, e.tag, e.bar_id, e.aperture, e.tc, e.attr});
        chk("R3 func", a.func, e.func);
        chk("R4 byte_addr", a.byte_addr, e.byte_addr);
        chk("R5 offset", a.offset, e.offset);
        chk("R6 zero_len", a.zero_len, e.zero_len);
        chk("R7 non_posted", a.non_posted, e.non_posted);
        chk("R9 message", {a.is_msg, a.msg_code, a.msg_route, a.dest_id, a.dest_vld},
                          {e.is_msg, e.msg_code, e.msg_route, e.dest_id, e.dest_vld});
    endtask

    // 128-bit packet; called just after a falling edge
    task automatic send_a(input logic [127:0] d, input logic [3:0] be, input int npay, input bit do_pop);
        obs_t e = expect_of(d, be, 1'b0);
        a_tdata = d; a_be = be; a_tvalid = 1; a_tlast = (npay == 0);
        #1;
        chk("R10 no pl_valid on descriptor", a_pl_valid, 1'b0);
        chk("R8 ready", a_tready, 1'b1);
        @(posedge clk); @(negedge clk);
        chk("R1 dec_valid", a_dv, 1'b1);
        chk_fields(a_obs, e);
        for (int p = 0; p < npay; p++) begin
            a_tdata = ~d ^ 128'(p + 1); a_tlast = (p == npay - 1);
            #1;
            chk("R10 pl_valid", a_pl_valid, 1'b1);
            chk("R10 pl_data", a_pl_data, ~d ^ 128'(p + 1));
            chk("R10 pl_last", a_pl_last, (p == npay - 1));
            @(posedge clk); @(negedge clk);
            if (p == 0) chk("R1 single pulse", a_dv, 1'b0);
        end
        a_tvalid = 0; a_tlast = 0;
        if (do_pop) begin
            #1;
            chk("R7 ctx_valid", a_ctx_valid, e.non_posted);
            if (e.non_posted) begin
                chk("R7 ctx fields", {a_crid, a_ctag, a_ctc, a_cattr}, {e.req_id, e.tag, e.tc, e.attr});
                a_pop = 1; @(posedge clk); @(negedge clk); a_pop = 0;
            end
        end
    endtask

    task automatic send_b(input logic [127:0] d, input logic [3:0] be, input int npay);
        obs_t e = expect_of(d, be, 1'b1);
        b_tdata = d[63:0]; b_be = be; b_tvalid = 1; b_tlast = 0;
        @(posedge clk); @(negedge clk);
        chk("R1 no dec_valid after first half", b_dv, 1'b0);
        b_tdata = d[127:64]; b_be = 4'hF ^ be; b_tlast = (npay == 0);
        #1;
        chk("R10 no pl_valid on upper half", b_pl_valid, 1'b0);
        @(posedge clk); @(negedge clk);
        chk("R1 dec_valid 64", b_dv, 1'b1);
        chk_fields(b_obs, e);
        for (int p = 0; p < npay; p++) begin
            b_tdata = d[63:0] ^ 64'(p + 7); b_tlast = (p == npay - 1);
            #1;
            chk("R10 pl_data 64", {b_pl_valid, b_pl_data}, {1'b1, d[63:0] ^ 64'(p + 7)});
            @(posedge clk); @(negedge clk);
        end
        b_tvalid = 0; b_tlast = 0;
        #1;
        chk("R7 ctx_valid 64", b_ctx_valid, e.non_posted);
        if (e.non_posted) begin
            chk("R7 ctx fields 64", {b_crid, b_ctag, b_ctc, b_cattr}, {e.req_id, e.tag, e.tc, e.attr});
            b_pop = 1; @(posedge clk); @(negedge clk); b_pop = 0;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [127:0] d;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 reset u0", {a_dv, a_ctx_valid, a_pl_valid, a_tready}, 4'b0001);
        chk("R11 reset u1", {b_dv, b_ctx_valid, b_pl_valid, b_tready}, 4'b0001);

        for (int t = 0; t < 16; t++)
            for (int be = 0; be < 16; be++)
                send_a(mk_desc(t, be), 4'(be), (t + be) % 3, 1'b1);

        for (int t = 0; t < 16; t++)
            for (int k = 0; k < 4; k++)
                send_b(mk_desc(t, 3 * k + 1), (k == 0) ? 4'h0 : 4'(1 << k), (t + k) % 3);

        // R8 back-pressure: fill queue with four reads
        for (int i = 0; i < 4; i++) begin
            d = mk_desc(0, 1); d[103:96] = 8'hC0 + 8'(i);
            send_a(d, 4'hF, 0, 1'b0);
        end
        d = mk_desc(1, 2);
        send_a(d, 4'h3, 1, 1'b0);            // posted write still flows
        d = mk_desc(0, 5); d[103:96] = 8'hC9;
        a_tdata = d; a_be = 4'h1; a_tvalid = 1; a_tlast = 1;
        #1;
        chk("R8 ready low when full", a_tready, 1'b0);
        @(posedge clk); @(negedge clk);
        chk("R8 held beat not decoded", a_dv, 1'b0);
        a_pop = 1;
        @(posedge clk); @(negedge clk);
        a_pop = 0;
        #1;
        chk("R8 ready after pop", a_tready, 1'b1);
        @(posedge clk); @(negedge clk);
        a_tvalid = 0; a_tlast = 0;
        chk("R8 held beat decoded", {a_dv, a_obs.tag}, {1'b1, 8'hC9});
        for (int i = 1; i <= 4; i++) begin
            #1;
            chk("R7 queue order", {a_ctx_valid, a_ctag}, {1'b1, (i == 4) ? 8'hC9 : 8'hC0 + 8'(i)});
            a_pop = 1; @(posedge clk); @(negedge clk); a_pop = 0;
        end
        #1;
        chk("R7 queue drained", a_ctx_valid, 1'b0);
        finish_run();
    end

endmodule